// File: doc/BRIEF.md
# Instruction Group Hazard Checker

This block watches a stream of 128-bit instruction bundles and enforces the grouping rule a scheduling compiler must follow. Each bundle carries a small template field and three instruction slots. Instructions between two stops form one group. A group may span several bundles, and a stop may fall after any of the three slots. Inside a group, no instruction may read a register that an earlier instruction of the group wrote. No two instructions of a group may write the same register. The checker keeps a mask of registers written so far in the open group. It checks the slots of each accepted bundle in order 0, 1, 2 and clears the mask at every stop. It reports a read-after-write or write-after-write violation together with the slot that caused it. It also pulses a group-end flag for any bundle that closes a group. It never executes anything.

The control is a two-state machine. `ST_EMPTY` means no instruction has entered the current group. `ST_OPEN` means at least one has. On an accepted bundle, transition T_CLOSE goes to `ST_EMPTY` when the bundle ends with a stop after slot 2. Transition T_OPEN goes to `ST_OPEN` otherwise. Idle cycles hold the state. Reset enters `ST_EMPTY`.

Top module: `hzd_checker`

## Requirements
- R1: After reset, or a reset in the middle of a group, all outputs are low and the written-register mask is empty. A register written before the reset causes no hazard afterwards.
- R2: The template field is bundle bits [4:0]. Slot k occupies bits [5+41k +: 41]. Inside a slot, bits [6:0] are the destination register, [13:7] the first source and [20:14] the second source. Bit 21 enables the write, bit 22 enables the first read and bit 23 enables the second read.
- R3: A slot that reads a register written earlier in the same group raises `raw_err` in the cycle after the bundle is accepted.
- R4: A slot that writes a register already written in the same group raises `waw_err` in the cycle after the bundle is accepted.
- R5: Register 0 is never recorded as written. Reading or writing register 0 never raises a violation.
- R6: Template bit k (k = 0, 1, 2) places a stop after slot k. The mask is cleared after that slot, and later slots of the same bundle start a new group.
- R7: Without a stop, the mask carries over into the next accepted bundle, so a group spans bundles.
- R8: `group_end` is high for one cycle, the cycle after an accepted bundle whose template bits [2:0] are not all zero.
- R9: When several slots of a bundle violate, `err_slot` gives the lowest such slot. `raw_err` and `waw_err` show that slot's own violation kinds, both if it has both. `err_slot` is 0 when there is no violation.
- R10: A violation does not stop checking, and the violating write is still recorded. Outputs last one cycle. A cycle with `bundle_valid` low drives all outputs low and leaves the mask unchanged.
- R11: Template bits [4:3] and slot bits [40:24] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bundle_valid | input | 1 | Bundle on `bundle` is accepted this cycle |
| bundle | input | 128 | Template field and three instruction slots |
| raw_err | output | 1 | Read-after-write violation in the reported slot |
| waw_err | output | 1 | Write-after-write violation in the reported slot |
| err_slot | output | 2 | Index of the lowest violating slot |
| group_end | output | 1 | The accepted bundle contained at least one stop |

## Verification
The bench targets stops in the middle of a bundle. A design that cleared the mask only at the bundle boundary would flag slot 2 after a stop placed after slot 0 or slot 1. It drives groups that span bundles, which catch a design that wrongly resets the mask per bundle. It drives slots that violate the rules several times in one bundle, where a wrong priority would report the wrong slot. Register 0 traffic catches a mask that records the constant register. The tests cover idle cycles carrying hazardous data and a reset in the middle of a group. These catch a design that samples bundles without checking the valid flag, or one that keeps stale mask bits. Set unused template and slot bits check that no decoder reads outside its fields.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Group tracking state
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_OPEN  = 1'b1
    } grp_st_t;

    localparam int DEF_BUNDLE_W = 128;
    localparam int DEF_SLOT_W   = 41;
    localparam int DEF_TMPL_W   = 5;
    localparam int DEF_NSLOT    = 3;
    localparam int DEF_REG_AW   = 7;

endpackage

// File: rtl/hzd_slot_dec.sv
module hzd_slot_dec #(
    parameter int SLOT_W = 41,
    parameter int REG_AW = 7
) (
    input  logic [SLOT_W-1:0] slot_bits,
    output logic [REG_AW-1:0] dst,
    output logic [REG_AW-1:0] src_a,
    output logic [REG_AW-1:0] src_b,
    output logic              wr,
    output logic              rd_a,
    output logic              rd_b
);
    localparam int A_LO   = REG_AW;
    localparam int B_LO   = 2 * REG_AW;
    localparam int EN_LO  = 3 * REG_AW;
    localparam int USED_W = EN_LO + 3;

    logic unused_hi;

    assign dst   = slot_bits[REG_AW-1:0];
    assign src_a = slot_bits[A_LO +: REG_AW];
    assign src_b = slot_bits[B_LO +: REG_AW];

    // Register 0 is constant, so it never enters or matches the mask
    assign wr   = slot_bits[EN_LO]     && (dst   != '0);
    assign rd_a = slot_bits[EN_LO + 1] && (src_a != '0);
    assign rd_b = slot_bits[EN_LO + 2] && (src_b != '0);

    assign unused_hi = ^slot_bits[SLOT_W-1:USED_W];
endmodule

// File: rtl/hzd_chain.sv
module hzd_chain #(
    parameter int NSLOT  = 3,
    parameter int REG_AW = 7,
    parameter int NREG   = 128
) (
    input  logic [NREG-1:0]              mask_in,
    input  logic [NSLOT-1:0][REG_AW-1:0] dst,
    input  logic [NSLOT-1:0][REG_AW-1:0] src_a,
    input  logic [NSLOT-1:0][REG_AW-1:0] src_b,
    input  logic [NSLOT-1:0]             wr,
    input  logic [NSLOT-1:0]             rd_a,
    input  logic [NSLOT-1:0]             rd_b,
    input  logic [NSLOT-1:0]             stop,
    output logic [NSLOT-1:0]             raw_hit,
    output logic [NSLOT-1:0]             waw_hit,
    output logic [NREG-1:0]              mask_out
);
    logic [NREG-1:0] run;

    // Slots are visited in program order; each sees the writes of the
    // slots before it, and a stop wipes the set before the next slot.
    always_comb begin
        run     = mask_in;
        raw_hit = '0;
        waw_hit = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if ((rd_a[i] && run[src_a[i]]) || (rd_b[i] && run[src_b[i]]))
                raw_hit[i] = 1'b1;
            if (wr[i] && run[dst[i]])
                waw_hit[i] = 1'b1;
            if (wr[i])
                run[dst[i]] = 1'b1;
            if (stop[i])
                run = '0;
        end
        mask_out = run;
    end
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker
    import hzd_pkg::*;
#(
    parameter int BUNDLE_W = DEF_BUNDLE_W,
    parameter int SLOT_W   = DEF_SLOT_W,
    parameter int TMPL_W   = DEF_TMPL_W,
    parameter int NSLOT    = DEF_NSLOT,
    parameter int REG_AW   = DEF_REG_AW,
    localparam int SLOT_IW = $clog2(NSLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bundle_valid,
    input  logic [BUNDLE_W-1:0] bundle,
    output logic                raw_err,
    output logic                waw_err,
    output logic [SLOT_IW-1:0]  err_slot,
    output logic                group_end
);
    localparam int NREG = 1 << REG_AW;

    grp_st_t st_q, st_d;
    logic [NREG-1:0]              mask_q, mask_nx;
    logic [NSLOT-1:0][REG_AW-1:0] dst_v, srca_v, srcb_v;
    logic [NSLOT-1:0]             wr_v, rda_v, rdb_v, stop_v;
    logic [NSLOT-1:0]             raw_v, waw_v;
    logic                         raw_d, waw_d, gend_d;
    logic [SLOT_IW-1:0]           slot_d;
    logic                         unused_tmpl;

    assign unused_tmpl = ^bundle[TMPL_W-1:NSLOT];

    // Per-slot field decode and stop table
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign stop_v[g] = bundle[g];
        hzd_slot_dec #(.SLOT_W(SLOT_W), .REG_AW(REG_AW)) u_dec (
            .slot_bits (bundle[TMPL_W + g*SLOT_W +: SLOT_W]),
            .dst       (dst_v[g]),
            .src_a     (srca_v[g]),
            .src_b     (srcb_v[g]),
            .wr        (wr_v[g]),
            .rd_a      (rda_v[g]),
            .rd_b      (rdb_v[g])
        );
    end

    hzd_chain #(.NSLOT(NSLOT), .REG_AW(REG_AW), .NREG(NREG)) u_chain (
        .mask_in  (mask_q),
        .dst      (dst_v),
        .src_a    (srca_v),
        .src_b    (srcb_v),
        .wr       (wr_v),
        .rd_a     (rda_v),
        .rd_b     (rdb_v),
        .stop     (stop_v),
        .raw_hit  (raw_v),
        .waw_hit  (waw_v),
        .mask_out (mask_nx)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (bundle_valid) st_d = stop_v[NSLOT-1] ? ST_EMPTY : ST_OPEN;
            ST_OPEN:  if (bundle_valid) st_d = stop_v[NSLOT-1] ? ST_EMPTY : ST_OPEN;
        endcase
    end

    // State and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_EMPTY;
            mask_q <= '0;
        end else begin
            st_q <= st_d;
            if (bundle_valid) mask_q <= mask_nx;
        end
    end

    // Output decode: lowest violating slot wins
    always_comb begin
        raw_d  = 1'b0;
        waw_d  = 1'b0;
        slot_d = '0;
        gend_d = bundle_valid && (|stop_v);
        if (bundle_valid) begin
            for (int i = NSLOT - 1; i >= 0; i--) begin
                if (raw_v[i] || waw_v[i]) begin
                    raw_d  = raw_v[i];
                    waw_d  = waw_v[i];
                    slot_d = SLOT_IW'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_err   <= 1'b0;
            waw_err   <= 1'b0;
            err_slot  <= '0;
            group_end <= 1'b0;
        end else begin
            raw_err   <= raw_d;
            waw_err   <= waw_d;
            err_slot  <= slot_d;
            group_end <= gend_d;
        end
    end

    AST_EMPTY_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_EMPTY |-> mask_q == '0); // R6
    AST_SLOT0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMPTY && bundle_valid) |=> (!(raw_err || waw_err) || err_slot != '0)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bundle_valid |=> (!raw_err && !waw_err && !group_end)); // R10
    AST_IDLE_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bundle_valid |=> $stable(mask_q)); // R10
    AST_REG0_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[0]); // R5
    AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_err || waw_err) |-> int'(err_slot) < NSLOT); // R9
endmodule

// File: tb/tb_hzd_checker.sv
`timescale 1ns/1ps
module tb_hzd_checker;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bundle_valid = 1'b0;
    logic [127:0] bundle = '0;
    logic         raw_err, waw_err, group_end;
    logic [1:0]   err_slot;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hzd_checker dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bundle_valid (bundle_valid),
        .bundle       (bundle),
        .raw_err      (raw_err),
        .waw_err      (waw_err),
        .err_slot     (err_slot),
        .group_end    (group_end)
    );

    // Slot helper: en = {rd_b, rd_a, wr}
    function automatic logic [23:0] sl(input int d, input int a, input int b, input int en);
        return {3'(en), 7'(b), 7'(a), 7'(d)};
    endfunction

    typedef struct packed {
        logic [4:0]  t;
        logic        junk;
        logic [23:0] s0, s1, s2;
        logic        raw, waw;
        logic [1:0]  slot;
        logic        ge;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{5'b00100, 1'b0, sl(5,0,0,1),   sl(6,7,0,3),     sl(9,8,0,3),     1'b0,1'b0,2'd0,1'b1}, // R8 clean group
        '{5'b00000, 1'b0, sl(10,0,0,1),  sl(11,10,0,3),   sl(12,0,0,1),    1'b1,1'b0,2'd1,1'b0}, // R3
        '{5'b00000, 1'b0, sl(12,0,0,1),  sl(0,11,0,2),    sl(20,0,0,1),    1'b0,1'b1,2'd0,1'b0}, // R4 R7 R9
        '{5'b00001, 1'b0, sl(0,20,0,2),  sl(10,0,0,1),    sl(0,10,0,2),    1'b1,1'b0,2'd0,1'b1}, // R6 R10
        '{5'b00010, 1'b0, sl(0,0,0,1),   sl(0,0,0,3),     sl(10,0,0,1),    1'b0,1'b0,2'd0,1'b1}, // R5 R6
        '{5'b11000, 1'b1, sl(10,0,0,1),  sl(10,10,10,7),  sl(0,0,0,0),     1'b0,1'b1,2'd0,1'b0}, // R11
        '{5'b00100, 1'b0, sl(0,0,10,4),  sl(30,0,0,1),    sl(30,0,0,1),    1'b1,1'b0,2'd0,1'b1}, // R2 second source
        '{5'b00000, 1'b0, sl(127,0,0,1), sl(0,0,0,0),     sl(127,127,0,3), 1'b1,1'b1,2'd2,1'b0}, // R9 both kinds
        '{5'b00100, 1'b0, sl(0,126,0,2), sl(126,0,0,1),   sl(0,126,0,2),   1'b1,1'b0,2'd2,1'b1}, // R3 slot 2
        '{5'b00100, 1'b0, sl(0,127,0,2), sl(0,0,0,0),     sl(0,0,0,0),     1'b0,1'b0,2'd0,1'b1}  // R6 cleared
    };

    function automatic logic [127:0] mk(input logic [4:0] t, input logic junk,
                                        input logic [23:0] a, input logic [23:0] b,
                                        input logic [23:0] c);
        logic [127:0] v = '0;
        v[4:0]     = t;
        v[5 +: 24]  = a;
        v[46 +: 24] = b;
        v[87 +: 24] = c;
        if (junk) begin
            v[29 +: 17]  = '1;
            v[70 +: 17]  = '1;
            v[111 +: 17] = '1;
        end
        return v;
    endfunction

    task automatic step(input logic [127:0] b, input logic v);
        bundle = b;
        bundle_valid = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic r, input logic w,
                       input logic [1:0] s, input logic g);
        checks++;
        if (raw_err !== r || waw_err !== w || err_slot !== s || group_end !== g) begin
            failures++;
            $display("FAIL %s: got raw=%0b waw=%0b slot=%0d ge=%0b, expected raw=%0b waw=%0b slot=%0d ge=%0b",
                     req, raw_err, waw_err, err_slot, group_end, r, w, s, g);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        rst_n = 1'b0;
        step('0, 1'b0);
        step('0, 1'b0);
        chk("R1 reset", 0, 0, 2'd0, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(mk(TBL[i].t, TBL[i].junk, TBL[i].s0, TBL[i].s1, TBL[i].s2), 1'b1);
            chk($sformatf("R3/R4 vector %0d", i), TBL[i].raw, TBL[i].waw, TBL[i].slot, TBL[i].ge);
        end

        // R10: idle cycles carry hazardous data but leave outputs and mask alone
        step(mk(5'b00000, 1'b0, sl(50,0,0,1), sl(0,0,0,0), sl(0,0,0,0)), 1'b1);
        chk("R7 open group r50", 0, 0, 2'd0, 0);
        for (int k = 0; k < 3; k++) begin
            step(mk(5'b00111, 1'b0, sl(50,50,0,3), sl(50,0,0,1), sl(0,0,0,0)), 1'b0);
            chk("R10 idle quiet", 0, 0, 2'd0, 0);
        end
        step(mk(5'b00100, 1'b0, sl(0,50,0,2), sl(0,0,0,0), sl(0,0,0,0)), 1'b1);
        chk("R10 mask held across idle", 1, 0, 2'd0, 1);

        // R1: reset in the middle of a group forgets the written set
        step(mk(5'b00000, 1'b0, sl(60,0,0,1), sl(0,0,0,0), sl(0,0,0,0)), 1'b1);
        chk("R1 pre-reset write", 0, 0, 2'd0, 0);
        rst_n = 1'b0;
        step(mk(5'b00000, 1'b0, sl(60,60,0,3), sl(0,0,0,0), sl(0,0,0,0)), 1'b1);
        chk("R1 outputs in reset", 0, 0, 2'd0, 0);
        rst_n = 1'b1;
        step(mk(5'b00100, 1'b0, sl(0,60,0,2), sl(60,0,0,1), sl(0,0,0,0)), 1'b1);
        chk("R1 mask empty after reset", 0, 0, 2'd0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule